// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a serial slave on a two-wire management bus that lets a host read and write a small bank of 8-bit configuration registers. Both bus lines are oversampled by a fast system clock. The block finds start, repeated start and stop conditions on the sampled lines and answers to one fixed 7-bit device address. It pulls SDA low to acknowledge a byte and to send read data. The contents of every register are always present on a flat parallel output, where the rest of the chip uses them as settings.

After the address, the host sends a command byte. When the command's top bit is set, the remaining seven bits name one register for a single-byte write or read. When the top bit is clear, the access is a block transfer that starts at register 0. A block write carries a byte count ahead of its data. A block read opens with a count byte from the slave, followed by the registers in ascending order.

Top module: `smb_regbank`

## Requirements
- R1: The block acknowledges only an address byte whose upper seven bits equal 0x69 (0xD2 for write, 0xD3 for read). For any other address it drives no acknowledge, and the rest of that transaction has no effect on the registers.
- R2: A command byte with bit 7 = 1 selects single-byte access at the register index held in bits 6:0. A command byte with bit 7 = 0 selects block access starting at register 0.
- R3: A byte write (address+W, command, one data byte, stop) has each byte acknowledged and stores the data byte in the indexed register.
- R4: A byte read (address+W, command, repeated start, address+R) returns the indexed register most significant bit first. After the host's NACK the block releases SDA.
- R5: A block write (address+W, command 0x00, count, data bytes) stores its data bytes into registers 0, 1, 2, … in that order.
- R6: A block read (address+W, command 0x00, repeated start, address+R) returns the byte 0x08 first, then registers 0 to 7 in ascending order. The host acknowledges every byte except the last.
- R7: A stop after any complete data byte of a block write ends the transfer. Bytes already acknowledged remain stored.
- R8: After reset the registers hold 0x01 (index 0), 0x85 (index 1), 0xFF (indices 2 and 3) and 0x00 (indices 4 to 7), and SDA is released.
- R9: A single-byte access whose index is 8 or higher is acknowledged. Its write changes no register, and its read returns 0x00.
- R10: The SDA pull-down changes state only while SCL is low.
- R11: A start or stop condition in the middle of a byte abandons that byte. Nothing is written, and a new start begins a fresh address phase.
- R12: In a block write, data bytes past the announced count or past register 7 are acknowledged and discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| sda_drive_low | output | 1 | 1 = pull SDA low (acknowledge or data 0) |
| cfg_regs_o | output | 64 | Register contents, index i at bits 8*i+7 : 8*i |

## Verification
Two events can land in the same few cycles. The first is the register write strobe that a completed data byte produces. The second is a stop or start condition that closes the transfer right after that byte, or that cuts into the next byte partway through. The bench provokes the first case by stopping a block write immediately after the second data byte's acknowledge. It provokes the second by issuing a stop, and in another transaction a start, after only a few bits of a byte. It judges both on the parallel register output: the completed bytes must be present, the partial byte must leave no trace, and the following transaction must be acknowledged normally. Throughout every transaction, a monitor on the real SCL line flags any change of the SDA pull-down while SCL is high.

// File: rtl/smb_pkg.sv
// Shared types and power-up values for the two-wire register slave.
package smb_pkg;
    // Bit-level phase of the protocol engine.
    typedef enum logic [2:0] {PH_IDLE, PH_RX, PH_RXACK, PH_TX, PH_TXACK} phase_t;
    // Meaning of the byte currently being received.
    typedef enum logic [1:0] {RL_ADDR, RL_CMD, RL_CNT, RL_DATA} role_t;

    // Power-up value of register idx; indices not listed reset to zero.
    function automatic logic [7:0] reg_default(input int idx);
        case (idx)
            0:       return 8'h01;
            1:       return 8'h85;
            2, 3:    return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/smb_line_sync.sv
// Synchronises SCL and SDA into the system clock and flags SCL edges and
// start/stop conditions. Assumes each bus level lasts several clk cycles.
module smb_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [1:0] scl_ff, sda_ff;
    logic       scl_q, sda_q;

    // Two-flop synchronisers plus one history stage; the idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= 2'b11;
            sda_ff <= 2'b11;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[0], scl_i};
            sda_ff <= {sda_ff[0], sda_i};
            scl_q  <= scl_ff[1];
            sda_q  <= sda_ff[1];
        end
    end

    assign scl_o     = scl_ff[1];
    assign sda_o     = sda_ff[1];
    assign scl_rise  = scl_ff[1] & ~scl_q;
    assign scl_fall  = ~scl_ff[1] & scl_q;
    assign start_det = scl_ff[1] & scl_q & sda_q & ~sda_ff[1];
    assign stop_det  = scl_ff[1] & scl_q & ~sda_q & sda_ff[1];
endmodule

// File: rtl/smb_regs.sv
// Bank of NREG 8-bit registers with one write port, one combinational read
// port and a flat view of all contents. Out-of-range reads return zero.
module smb_regs import smb_pkg::*; #(
    parameter int NREG = 8,
    parameter int AW   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_idx,
    input  logic [7:0]        wr_data,
    input  logic [AW-1:0]     rd_idx,
    output logic [7:0]        rd_data,
    output logic [NREG*8-1:0] regs_flat
);
    logic [NREG*8-1:0] regs_q;
    logic              was_rst;

    // Register storage: defaults on reset, otherwise the addressed write.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (!rst_n)
                regs_q[i*8 +: 8] <= reg_default(i);
            else if (wr_en && wr_idx == AW'(i))
                regs_q[i*8 +: 8] <= wr_data;
        end
    end

    // Read mux; an index past the bank yields zero.
    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NREG; i++)
            if (rd_idx == AW'(i)) rd_data = regs_q[i*8 +: 8];
    end

    assign regs_flat = regs_q;

    // Tracks the cycle that follows a reset cycle, for the default check.
    always_ff @(posedge clk) was_rst <= !rst_n;

    always_ff @(posedge clk) begin
        if (rst_n && was_rst)
            for (int i = 0; i < NREG; i++)
                assert_reset_defaults_R8: assert (regs_q[i*8 +: 8] == reg_default(i))
                    else $error("register %0d not at default after reset", i);
    end

    assert_write_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < NREG));

    for (genvar g = 0; g < NREG; g++) begin : g_wchk
        assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == AW'(g)) |=> (regs_q[g*8 +: 8] == $past(wr_data)));
    end
endmodule

// File: rtl/smb_regbank.sv
// Two-wire bus slave giving a host byte and block access to a register bank.
// Assumes clk is at least ~10x the SCL rate; no clock stretching or PEC.
module smb_regbank import smb_pkg::*; #(
    parameter int         NREG     = 8,
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_drive_low,
    output logic [NREG*8-1:0] cfg_regs_o
);
    localparam int            AW       = 7;
    localparam logic [AW-1:0] LAST_IDX = AW'(NREG - 1);
    localparam logic [7:0]    CNT_BYTE = 8'(NREG);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    phase_t        phase;
    role_t         role;
    logic [2:0]    bcnt;
    logic [6:0]    rx_sr, tx_sr;
    logic [7:0]    rx_byte, wr_left, rd_data, next_tx;
    logic [AW-1:0] ptr, wr_idx;
    logic [7:0]    wr_data;
    logic          wr_en, byte_mode, byte_done, rd_next, cnt_pend, mack, drive, in_range;

    smb_line_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_o(scl_s), .sda_o(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    smb_regs #(.NREG(NREG), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(ptr), .rd_data(rd_data), .regs_flat(cfg_regs_o)
    );

    assign rx_byte  = {rx_sr, sda_s};
    assign in_range = (ptr <= LAST_IDX);
    assign next_tx  = cnt_pend ? CNT_BYTE : rd_data;

    // Protocol engine: byte framing, address/command decode, ack and read data.
    always_ff @(posedge clk) begin
        wr_en <= 1'b0;
        if (!rst_n) begin
            phase <= PH_IDLE;   role <= RL_ADDR;    bcnt <= '0;
            rx_sr <= '0;        tx_sr <= '0;        ptr <= '0;
            byte_mode <= 1'b0;  byte_done <= 1'b0;  wr_left <= '0;
            rd_next <= 1'b0;    cnt_pend <= 1'b0;   mack <= 1'b0;
            drive <= 1'b0;      wr_idx <= '0;       wr_data <= '0;
        end else if (start_det) begin
            phase <= PH_RX;
            role  <= RL_ADDR;
            bcnt  <= '0;
            drive <= 1'b0;
        end else if (stop_det) begin
            phase <= PH_IDLE;
            drive <= 1'b0;
        end else begin
            case (phase)
                PH_RX: if (scl_rise) begin
                    rx_sr <= rx_byte[6:0];
                    bcnt  <= bcnt + 3'd1;
                    if (bcnt == 3'd7) begin
                        phase <= PH_RXACK;
                        case (role)
                            RL_ADDR: begin
                                role    <= RL_CMD;
                                rd_next <= rx_byte[0];
                                if (rx_byte[7:1] != DEV_ADDR) phase <= PH_IDLE;
                            end
                            RL_CMD: begin
                                byte_mode <= rx_byte[7];
                                byte_done <= 1'b0;
                                cnt_pend  <= ~rx_byte[7];
                                ptr       <= rx_byte[7] ? rx_byte[6:0] : '0;
                                role      <= rx_byte[7] ? RL_DATA : RL_CNT;
                            end
                            RL_CNT: begin
                                wr_left <= rx_byte;
                                role    <= RL_DATA;
                            end
                            default: begin
                                wr_idx  <= ptr;
                                wr_data <= rx_byte;
                                if (byte_mode) begin
                                    wr_en     <= !byte_done && in_range;
                                    byte_done <= 1'b1;
                                end else begin
                                    wr_en <= (wr_left != 8'd0) && in_range;
                                    if (wr_left != 8'd0) wr_left <= wr_left - 8'd1;
                                    if (in_range) ptr <= ptr + AW'(1);
                                end
                            end
                        endcase
                    end
                end
                PH_RXACK: if (scl_fall) begin
                    if (!drive) begin
                        drive <= 1'b1;
                    end else if (rd_next) begin
                        phase <= PH_TX;
                        bcnt  <= '0;
                        tx_sr <= next_tx[6:0];
                        drive <= ~next_tx[7];
                        if (cnt_pend) cnt_pend <= 1'b0;
                        else if (in_range) ptr <= ptr + AW'(1);
                    end else begin
                        phase <= PH_RX;
                        bcnt  <= '0;
                        drive <= 1'b0;
                    end
                end
                PH_TX: if (scl_fall) begin
                    if (bcnt == 3'd7) begin
                        drive <= 1'b0;
                        mack  <= 1'b0;
                        phase <= PH_TXACK;
                    end else begin
                        bcnt  <= bcnt + 3'd1;
                        drive <= ~tx_sr[6];
                        tx_sr <= {tx_sr[5:0], 1'b0};
                    end
                end
                PH_TXACK: if (scl_rise) begin
                    if (sda_s) phase <= PH_IDLE;
                    else       mack  <= 1'b1;
                end else if (scl_fall && mack) begin
                    phase <= PH_TX;
                    bcnt  <= '0;
                    tx_sr <= next_tx[6:0];
                    drive <= ~next_tx[7];
                    if (cnt_pend) cnt_pend <= 1'b0;
                    else if (in_range) ptr <= ptr + AW'(1);
                end
                default: ;
            endcase
        end
    end

    assign sda_drive_low = drive;

    assert_sda_moves_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (drive != $past(drive)) |-> ($past(!scl_s) || $past(start_det) || $past(stop_det)));

    assert_idle_releases_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> !sda_drive_low);

    assert_start_restarts_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (phase == PH_RX && role == RL_ADDR && bcnt == 3'd0 && !sda_drive_low));
endmodule

// File: tb/smb_regbank_tb.sv
module smb_regbank_tb;
    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_drive_low;
    logic [63:0] cfg_regs_o;
    wire  sda_bus = sda_m & ~sda_drive_low;

    int checks = 0;
    int errors = 0;
    int viol = 0;
    logic prev_drv = 1'b0;
    logic [7:0] model [8];
    logic [7:0] blk [16];
    logic [7:0] rbuf [9];

    always #2.5 clk = ~clk;

    smb_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_drive_low(sda_drive_low), .cfg_regs_o(cfg_regs_o)
    );

    // R10 monitor: the pull-down may only toggle while the real SCL is low.
    always @(negedge clk) begin
        if (rst_n && sda_drive_low != prev_drv && scl_m) viol++;
        prev_drv <= sda_drive_low;
    end

    typedef struct packed {
        logic [7:0] off;
        logic [7:0] wdat;
        logic [7:0] rexp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{8'h00, 8'hA5, 8'hA5},
        '{8'h03, 8'h3C, 8'h3C},
        '{8'h07, 8'h81, 8'h81},
        '{8'h09, 8'h77, 8'h00},
        '{8'h05, 8'h00, 8'h00},
        '{8'h7F, 8'hEE, 8'h00},
        '{8'h02, 8'h5A, 8'h5A},
        '{8'h01, 8'hFF, 8'hFF}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] model_flat();
        logic [63:0] f;
        for (int i = 0; i < 8; i++) f[i*8 +: 8] = model[i];
        return f;
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); b = sda_bus; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    // Sends a byte MSB first; ack = 0 when the slave acknowledged.
    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(ack);
    endtask

    task automatic recv_byte(input bit master_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) bit_in(b[i]);
        bit_out(!master_ack);
    endtask

    task automatic byte_write(input logic [7:0] off, input logic [7:0] d, output logic nak);
        logic a0, a1, a2;
        bus_start(); send_byte(8'hD2, a0); send_byte({1'b1, off[6:0]}, a1);
        send_byte(d, a2); bus_stop();
        nak = a0 | a1 | a2;
    endtask

    task automatic byte_read(input logic [7:0] off, output logic [7:0] d, output logic nak);
        logic a0, a1, a2;
        bus_start(); send_byte(8'hD2, a0); send_byte({1'b1, off[6:0]}, a1);
        bus_start(); send_byte(8'hD3, a2); recv_byte(1'b0, d); bus_stop();
        nak = a0 | a1 | a2;
    endtask

    // Block write of nsend bytes from blk with the given count; updates model.
    task automatic block_write(input logic [7:0] cnt, input int nsend, output logic nak);
        logic a;
        nak = 1'b0;
        bus_start(); send_byte(8'hD2, a); nak |= a; send_byte(8'h00, a); nak |= a;
        send_byte(cnt, a); nak |= a;
        for (int i = 0; i < nsend; i++) begin
            send_byte(blk[i], a); nak |= a;
            if (i < int'(cnt) && i < 8) model[i] = blk[i];
        end
        bus_stop();
    endtask

    initial begin
        logic nak;
        logic [7:0] d;
        model = '{8'h01, 8'h85, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00};
        tick(4);
        rst_n = 1'b1;
        tick(4);

        // R8: reset values and released SDA.
        chk(cfg_regs_o == model_flat(), "R8 reset defaults", cfg_regs_o, model_flat());
        chk(sda_drive_low == 1'b0, "R8 SDA released after reset", 64'(sda_drive_low), 64'd0);

        // R2 R3 R4 R9: vector table of single-byte write then read-back.
        for (int v = 0; v < 8; v++) begin
            byte_write(VECS[v].off, VECS[v].wdat, nak);
            chk(nak == 1'b0, "R3 byte write acked", 64'(nak), 64'd0);
            if (VECS[v].off < 8) model[VECS[v].off[2:0]] = VECS[v].wdat;
            chk(cfg_regs_o == model_flat(), "R9 R3 register bank after byte write", cfg_regs_o, model_flat());
            byte_read(VECS[v].off, d, nak);
            chk(nak == 1'b0 && d == VECS[v].rexp, "R4 R2 byte read value", {55'd0, nak, d}, {56'd0, VECS[v].rexp});
        end

        // R1: a foreign address is not acknowledged, nor is the rest.
        bus_start(); send_byte(8'hA4, nak);
        chk(nak == 1'b1, "R1 foreign address NACKed", 64'(nak), 64'd1);
        send_byte(8'h80, nak);
        chk(nak == 1'b1, "R1 command after foreign address NACKed", 64'(nak), 64'd1);
        send_byte(8'h11, nak); bus_stop();
        chk(cfg_regs_o == model_flat(), "R1 foreign transaction leaves registers", cfg_regs_o, model_flat());

        // R5: block write of three bytes into registers 0..2.
        blk[0] = 8'h11; blk[1] = 8'h22; blk[2] = 8'h33;
        block_write(8'd3, 3, nak);
        chk(nak == 1'b0, "R5 block write acked", 64'(nak), 64'd0);
        chk(cfg_regs_o == model_flat(), "R5 block write order", cfg_regs_o, model_flat());

        // R12: bytes beyond the count are acked and dropped.
        blk[0] = 8'h44; blk[1] = 8'h55; blk[2] = 8'h66; blk[3] = 8'h77;
        block_write(8'd2, 4, nak);
        chk(nak == 1'b0, "R12 surplus bytes acked", 64'(nak), 64'd0);
        chk(cfg_regs_o == model_flat(), "R12 surplus bytes dropped", cfg_regs_o, model_flat());

        // R12: bytes beyond register 7 are acked and dropped.
        for (int i = 0; i < 10; i++) blk[i] = 8'hA0 + 8'(i);
        block_write(8'd10, 10, nak);
        chk(nak == 1'b0, "R12 overrun bytes acked", 64'(nak), 64'd0);
        chk(cfg_regs_o == model_flat(), "R12 overrun bytes dropped", cfg_regs_o, model_flat());

        // R7: stop after two complete bytes of a five-byte block.
        blk[0] = 8'hC1; blk[1] = 8'hC2;
        block_write(8'd5, 2, nak);
        chk(cfg_regs_o == model_flat(), "R7 early stop keeps written bytes", cfg_regs_o, model_flat());

        // R6: block read returns count 8 then registers ascending.
        bus_start(); send_byte(8'hD2, nak); send_byte(8'h00, nak);
        bus_start(); send_byte(8'hD3, nak);
        chk(nak == 1'b0, "R6 read address acked", 64'(nak), 64'd0);
        for (int i = 0; i < 9; i++) recv_byte(i != 8, rbuf[i]);
        bus_stop();
        chk(rbuf[0] == 8'h08, "R6 block read count", 64'(rbuf[0]), 64'h08);
        for (int i = 0; i < 8; i++)
            chk(rbuf[i+1] == model[i], "R6 block read data", 64'(rbuf[i+1]), 64'(model[i]));
        byte_read(8'h03, d, nak);
        chk(d == model[3], "R6 R4 byte read after block read", 64'(d), 64'(model[3]));

        // R11: stop in the middle of a data byte writes nothing.
        bus_start(); send_byte(8'hD2, nak); send_byte(8'h84, nak);
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b1);
        bus_stop();
        chk(cfg_regs_o == model_flat(), "R11 stop mid-byte discards", cfg_regs_o, model_flat());

        // R11: start in the middle of a byte restarts the address phase.
        bus_start(); send_byte(8'hD2, nak); send_byte(8'h85, nak);
        bit_out(1'b0); bit_out(1'b1); bit_out(1'b1);
        bus_start(); send_byte(8'hD2, nak);
        chk(nak == 1'b0, "R11 address after restart acked", 64'(nak), 64'd0);
        send_byte(8'h85, nak); send_byte(8'h42, nak); bus_stop();
        model[5] = 8'h42;
        chk(cfg_regs_o == model_flat(), "R11 restarted transaction writes", cfg_regs_o, model_flat());

        // R10: no pull-down change while SCL was high.
        chk(viol == 0, "R10 SDA changes only with SCL low", 64'(viol), 64'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule